// File: doc/BRIEF.md
# Condition Bit Logic Unit

This block keeps a 32-bit condition word, viewed as eight 4-bit fields, and performs one condition-word operation per clock. Eight operations combine two single bits of the word and write the result into a third bit. A ninth operation copies one whole 4-bit field into another. The bits are numbered with index 0 as the most significant bit.

A caller raises `op_valid` together with an operation code and the operand indices. The word updates at the next rising edge, and `done` pulses one cycle after that. A separate load strobe replaces the entire word at once. The full word is always readable on `cr_q`.

Top module: `crbit_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `cr_q` to zero and holds `done` low in the following cycle.
- R2: Bit index i (0..31) names `cr_q[31-i]`, so index 0 is the most significant bit.
- R3: `op_code` selects the result from A (the bit at `src_a_idx`) and B (the bit at `src_b_idx`), as follows. 0 gives A&B. 1 gives ~(A&B). 2 gives A|B. 3 gives A^B. 4 gives ~(A|B). 5 gives ~(A^B). 6 gives A&~B. 7 gives A|~B. The result is written to the bit at `dst_idx`.
- R4: A bit operation (codes 0..7) changes at most the one bit at `dst_idx`. The other 31 bits keep their values.
- R5: Code 8 copies field `src_fld` into field `dst_fld`. Field f is `cr_q[31-4f:28-4f]`, so field 0 is the top nibble. Only the destination field may change.
- R6: Every operand is read from the word as it stood before the write. This holds even when the indices coincide, for example when all three name the same bit or when a field is copied onto itself.
- R7: Codes 9..15 leave `cr_q` unchanged.
- R8: When `ld_en` is high, `cr_q` takes `ld_data` at the next edge. This has priority over an operation issued in the same cycle.
- R9: An operation with `op_valid` high in cycle N updates `cr_q` at the edge that ends cycle N. `done` is then high during cycle N+2 for one cycle. This happens for every valid cycle, including unused codes and operations overridden by a load.
- R10: With neither `op_valid` nor `ld_en` high, `cr_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Whole-word load strobe |
| ld_data | input | 32 | Value for a whole-word load |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation select (0..8 used) |
| dst_idx | input | 5 | Destination bit index |
| src_a_idx | input | 5 | First source bit index |
| src_b_idx | input | 5 | Second source bit index |
| dst_fld | input | 3 | Destination field for the field copy |
| src_fld | input | 3 | Source field for the field copy |
| cr_q | output | 32 | Current condition word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The new value of `cr_q` is due one edge after the cycle that carries `op_valid` or `ld_en`. The `done` pulse is due one edge later still. The bench drives its inputs at falling edges. At each rising edge it advances its own model of the word and of a two-stage done delay. At the next falling edge it compares both outputs, so every result is checked in exactly the cycle it is due. Directed phases cover each operation code, coinciding operand indices, field copies, unused codes and a load that collides with an operation. A random phase then mixes all of these.

// File: rtl/crbit_unit.sv
module crbit_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_en,
  input  logic [31:0] ld_data,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic [4:0]  dst_idx,
  input  logic [4:0]  src_a_idx,
  input  logic [4:0]  src_b_idx,
  input  logic [2:0]  dst_fld,
  input  logic [2:0]  src_fld,
  output logic [31:0] cr_q,
  output logic        done
);

  logic [31:0] cr_r, cr_nxt;
  logic        pend_r, done_r;
  logic        a_bit, b_bit, res;
  logic [4:0]  dst_lsb, src_lsb;

  assign a_bit   = cr_r[5'd31 - src_a_idx];
  assign b_bit   = cr_r[5'd31 - src_b_idx];
  assign dst_lsb = {3'd7 - dst_fld, 2'b00};
  assign src_lsb = {3'd7 - src_fld, 2'b00};

  always_comb begin
    case (op_code[2:0])
      3'd0:    res = a_bit & b_bit;
      3'd1:    res = ~(a_bit & b_bit);
      3'd2:    res = a_bit | b_bit;
      3'd3:    res = a_bit ^ b_bit;
      3'd4:    res = ~(a_bit | b_bit);
      3'd5:    res = ~(a_bit ^ b_bit);
      3'd6:    res = a_bit & ~b_bit;
      default: res = a_bit | ~b_bit;
    endcase
  end

  always_comb begin
    cr_nxt = cr_r;
    if (ld_en)
      cr_nxt = ld_data;
    else if (op_valid) begin
      if (!op_code[3])
        cr_nxt[5'd31 - dst_idx] = res;
      else if (op_code == 4'd8)
        cr_nxt[dst_lsb +: 4] = cr_r[src_lsb +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_r   <= '0;
      pend_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      cr_r   <= cr_nxt;
      pend_r <= op_valid;
      done_r <= pend_r;
    end
  end

  assign cr_q = cr_r;
  assign done = done_r;

  function automatic logic [31:0] fld_mask(input logic [2:0] f);
    return 32'hF << {3'd7 - f, 2'b00};
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cr_q == 32'd0 && !done));

  assert_single_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ld_en && !op_code[3]) |=> ($countones(cr_q ^ $past(cr_q)) <= 1));

  assert_field_only_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ld_en && op_code == 4'd8)
      |=> (((cr_q ^ $past(cr_q)) & ~fld_mask($past(dst_fld))) == 32'd0));

  assert_unused_code_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ld_en && op_code > 4'd8) |=> $stable(cr_q));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (cr_q == $past(ld_data)));

  assert_done_delay_R9: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> ##1 done);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !ld_en) |=> $stable(cr_q));

endmodule

// File: tb/tb_crbit_unit.sv
module tb_crbit_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [4:0]  dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
  logic [2:0]  dst_fld = '0, src_fld = '0;
  logic [31:0] cr_q;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit [31:0] m_cr = '0;
  bit        m_pend = 0, m_done = 0;

  always #2 clk = ~clk;

  crbit_unit dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_data(ld_data),
    .op_valid(op_valid), .op_code(op_code), .dst_idx(dst_idx),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .dst_fld(dst_fld), .src_fld(src_fld), .cr_q(cr_q), .done(done)
  );

  function automatic int get_bit(bit [31:0] w, int idx);
    return (w >> (31 - idx)) & 1;
  endfunction

  function automatic bit [31:0] model_next(bit [31:0] w);
    int a, b, r, nib;
    bit [31:0] n;
    n = w;
    if (ld_en) return ld_data;
    if (!op_valid) return w;
    a = get_bit(w, int'(src_a_idx));
    b = get_bit(w, int'(src_b_idx));
    case (int'(op_code))
      0: r = a & b;
      1: r = 1 - (a & b);
      2: r = a | b;
      3: r = a ^ b;
      4: r = 1 - (a | b);
      5: r = 1 - (a ^ b);
      6: r = a & (1 - b);
      7: r = a | (1 - b);
      8: r = -1;
      default: return w;
    endcase
    if (r >= 0) begin
      if (r == 1) n = n | (32'h8000_0000 >> int'(dst_idx));
      else        n = n & ~(32'h8000_0000 >> int'(dst_idx));
    end else begin
      nib = (w >> (28 - 4 * int'(src_fld))) & 15;
      n = n & ~(32'hF000_0000 >> (4 * int'(dst_fld)));
      n = n | (32'(nib) << (28 - 4 * int'(dst_fld)));
    end
    return n;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (cr_q !== m_cr) begin
      errors++;
      $display("FAIL %s cr_q actual %h expected %h", tag, cr_q, m_cr);
    end
    checks++;
    if (done !== m_done) begin
      errors++;
      $display("FAIL R9 done actual %b expected %b (during %s)", done, m_done, tag);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    if (rst) begin
      m_cr = '0; m_pend = 0; m_done = 0;
    end else begin
      m_cr   = model_next(m_cr);
      m_done = m_pend;
      m_pend = op_valid;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    ld_en = 0; op_valid = 0;
  endtask

  task automatic load(bit [31:0] v, string tag);
    idle(); ld_en = 1; ld_data = v;
    step(tag);
    ld_en = 0;
  endtask

  task automatic bitop(int op, int t, int a, int b, string tag);
    idle(); op_valid = 1; op_code = 4'(op);
    dst_idx = 5'(t); src_a_idx = 5'(a); src_b_idx = 5'(b);
    step(tag);
    op_valid = 0;
  endtask

  task automatic fldop(int op, int d, int s, string tag);
    idle(); op_valid = 1; op_code = 4'(op);
    dst_fld = 3'(d); src_fld = 3'(s);
    step(tag);
    op_valid = 0;
  endtask

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    step("R1");
    step("R10");

    load(32'h8000_0001, "R8");
    bitop(0, 5, 0, 31, "R2");
    step("R2");
    for (int op = 0; op < 8; op++) begin
      for (int ab = 0; ab < 4; ab++) begin
        load(32'h0000_0000 | ((ab >> 1) ? 32'h4000_0000 : 0) | ((ab & 1) ? 32'h0000_0002 : 0), "R8");
        bitop(op, 10, 1, 30, "R3");
        bitop(op, 0, 1, 30, "R3");
        step("R4");
      end
    end

    load(32'hA5A5_5A5A, "R8");
    for (int op = 0; op < 8; op++) begin
      bitop(op, 7, 7, 7, "R6");
      bitop(op, 31, 31, 0, "R6");
    end
    step("R6");

    load(32'h0123_4567, "R8");
    fldop(8, 0, 7, "R5");
    fldop(8, 7, 0, "R5");
    fldop(8, 3, 3, "R6");
    fldop(8, 5, 2, "R5");
    step("R5");

    for (int op = 9; op < 16; op++) begin
      bitop(op, 4, 9, 12, "R7");
      fldop(op, 1, 6, "R7");
    end
    step("R7");

    idle(); ld_en = 1; ld_data = 32'hDEAD_BEEF; op_valid = 1; op_code = 4'd1;
    dst_idx = 5'd0; src_a_idx = 5'd0; src_b_idx = 5'd0;
    step("R8");
    idle();
    step("R9"); step("R9"); step("R10");

    for (int k = 0; k < 3000; k++) begin
      ld_en     = ($urandom_range(0, 15) == 0);
      ld_data   = $urandom;
      op_valid  = ($urandom_range(0, 3) != 0);
      op_code   = 4'($urandom_range(0, 15));
      dst_idx   = 5'($urandom);
      src_a_idx = 5'($urandom);
      src_b_idx = 5'($urandom);
      dst_fld   = 3'($urandom);
      src_fld   = 3'($urandom);
      step("R4");
    end
    idle();
    step("R9"); step("R9");

    rst = 1;
    step("R1");
    rst = 0;
    step("R1");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule